// File: doc/BRIEF.md
# Redundant Radix Pipeline Code Combiner

This block turns the raw decisions of one pipelined converter slice into a single signed binary sample. Each sample has three parts. The first is a thermometer word from a 15-level first-stage flash. The second is one decision bit from each of fifteen later stages. The third is the digital value of the dither that was injected on the analog side. The later stages have a nominal inter-stage gain of about 1.7, so their weights form a redundant, non-binary series. A binary shift-and-add would therefore be wrong, and every stage is scaled by its own weight instead.

The flash step and the weights of the first ten single-bit stages sit in programmable registers, which are loaded through a simple write port. The last five single-bit stages use fixed nominal weights that continue the same radix series. All weights are unsigned fixed-point values with six fractional bits below the output LSB. The weighted terms are summed, the dither is subtracted, and the sum is rounded to nearest. The result is then saturated to a 14-bit two's-complement code. The datapath is fully pipelined: it takes one sample per clock and delivers each result with a valid strobe a fixed four cycles later.

Top module: `pipe_code_combiner`

## Requirements
- R1: A sample presented with `in_valid` high before rising edge N appears on `out_code` with `out_valid` high after rising edge N+3. `out_valid` is low in every cycle whose matching input cycle had `in_valid` low.
- R2: The flash contributes (k − 7) × flash step weight, where k is the number of ones in the 14-bit `flash_therm`. Only the count matters, so a thermometer with bubbles gives the same result as a clean one with the same count.
- R3: Bit i of `stage_bits` is the decision of single-bit stage i+2, for i from 0 to 14. It adds +weight when it is 1 and −weight when it is 0.
- R4: Weight register address 0 holds the flash step, and addresses 1 to 10 hold the weights of stages 2 to 11, which are bits 0 to 9 of `stage_bits`. A write applies to every sample captured at the edge of the write or at any later edge.
- R5: Stages 12 to 16 use fixed weights. Each one is floor(previous × 10 / 17), and the chain starts from the reset weight of stage 11.
- R6: The value on `dither`, read as a signed number in the same fixed-point units as the weights, is subtracted from the weighted sum.
- R7: The output is floor((S + 32) / 64), where S is the fixed-point sum after dither removal. Ties therefore round toward positive infinity.
- R8: Results above 8191 are output as 8191, and results below −8192 are output as −8192.
- R9: A write to an address from 11 to 15 changes no weight.
- R10: Reset clears `out_valid` and `out_code` to 0. It also restores the flash step to 65536 and the stage 2 weight to 38400. Each later calibratable stage returns to floor(previous × 10 / 17).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Weight register write strobe |
| wr_addr | input | 4 | Weight register address (0 flash step, 1..10 stages 2..11) |
| wr_data | input | 18 | Unsigned weight, 6 fractional bits |
| in_valid | input | 1 | Input sample valid |
| flash_therm | input | 14 | First-stage flash comparator outputs |
| stage_bits | input | 15 | Decisions of stages 2..16, bit 0 = stage 2 |
| dither | input | 24 | Signed dither value in weight units |
| out_valid | output | 1 | Result valid strobe |
| out_code | output | 14 | Signed two's-complement result |

## Verification
The result of every sample is due at the fourth rising edge, counting the edge that captures it. The bench drives inputs on falling edges and keeps a four-entry ring of expected results. At each falling edge it compares the outputs with the entry stored four falling edges earlier, and then overwrites that entry. Idle slots check that `out_valid` is low. Weight writes are issued in idle cycles, and the bench model updates its weights before it computes the expectation of any later sample. After a reset the ring is cleared, because the pipeline is empty for four cycles.

// File: rtl/ccmb_pkg.sv
package ccmb_pkg;

    localparam int     CCMB_OUT_W        = 14;
    localparam int     CCMB_FRAC         = 6;
    localparam int     CCMB_WGT_W        = 18;
    localparam int     CCMB_FLASH_LEVELS = 15;
    localparam int     CCMB_BIT_STAGES   = 15;
    localparam int     CCMB_CAL_STAGES   = 10;
    localparam int     CCMB_DITH_W       = 24;
    localparam longint CCMB_FLASH_NOM    = 65536;
    localparam longint CCMB_STAGE_NOM    = 38400;

    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_HIGH = 2'd1,
        SAT_LOW  = 2'd2
    } sat_e;

    // Nominal weight of the single-bit stage idx positions after the first,
    // each step dividing by the nominal radix 1.7 (as 10/17, floored).
    function automatic longint chain_weight(longint base, int idx);
        longint w;
        w = base;
        for (int i = 0; i < idx; i++) begin
            w = (w * 10) / 17;
        end
        return w;
    endfunction

endpackage

// File: rtl/ccmb_weight_regs.sv
module ccmb_weight_regs
    import ccmb_pkg::*;
#(
    parameter int     WW        = CCMB_WGT_W,
    parameter int     NBIT      = CCMB_BIT_STAGES,
    parameter int     NCAL      = CCMB_CAL_STAGES,
    parameter int     AW        = 4,
    parameter longint FLASH_NOM = CCMB_FLASH_NOM,
    parameter longint STAGE_NOM = CCMB_STAGE_NOM
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [WW-1:0]            wr_data,
    output logic [WW-1:0]            flash_w,
    output logic [NBIT-1:0][WW-1:0]  stage_w
);
    localparam int NREG = NCAL + 1;

    logic [NREG-1:0][WW-1:0] regs_q;
    logic                    wr_hit;

    function automatic logic [WW-1:0] reset_value(int idx);
        if (idx == 0) begin
            return WW'(FLASH_NOM);
        end
        return WW'(chain_weight(STAGE_NOM, idx - 1));
    endfunction

    assign wr_hit = wr_en && (int'(wr_addr) < NREG);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= reset_value(i);
            end
        end else if (wr_hit) begin
            regs_q[wr_addr] <= wr_data;
        end
    end

    assign flash_w = regs_q[0];

    generate
        for (genvar k = 0; k < NBIT; k++) begin : g_stage_w
            if (k < NCAL) begin : g_cal
                assign stage_w[k] = regs_q[k+1];
            end else begin : g_fixed
                assign stage_w[k] = WW'(chain_weight(STAGE_NOM, k));
            end
        end
    endgenerate

    // R4: an accepted write is visible in the addressed register next cycle
    assert_wr_lands_R4: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> regs_q[$past(wr_addr)] == $past(wr_data));

    // R9: writes to unused addresses leave every weight unchanged
    assert_wr_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_hit) |=> $stable(regs_q));

endmodule

// File: rtl/ccmb_flash_decode.sv
module ccmb_flash_decode
    import ccmb_pkg::*;
#(
    parameter int LEVELS = CCMB_FLASH_LEVELS,
    parameter int LW     = $clog2(LEVELS) + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LEVELS-2:0]     thermo,
    output logic signed [LW-1:0]  level_q
);
    localparam int HALF = (LEVELS - 1) / 2;

    logic [LW-1:0]        cnt;
    logic signed [LW-1:0] level_c;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < LEVELS - 1; i++) begin
            cnt = cnt + LW'(thermo[i]);
        end
        level_c = $signed(cnt) - LW'(HALF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else begin
            level_q <= level_c;
        end
    end

    // R2: full-scale thermometer words map to the symmetric extremes
    assert_full_scale_hi_R2: assert property (@(posedge clk) disable iff (rst)
        (&thermo) |=> level_q == LW'(HALF));

    assert_full_scale_lo_R2: assert property (@(posedge clk) disable iff (rst)
        (thermo == '0) |=> level_q == -LW'(HALF));

endmodule

// File: rtl/ccmb_term_sum.sv
module ccmb_term_sum
    import ccmb_pkg::*;
#(
    parameter int WW   = CCMB_WGT_W,
    parameter int NBIT = CCMB_BIT_STAGES,
    parameter int LW   = 5,
    parameter int DW   = CCMB_DITH_W,
    parameter int SW   = 29
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [LW-1:0]     level,
    input  logic [NBIT-1:0]          bits,
    input  logic signed [DW-1:0]     dith,
    input  logic [WW-1:0]            flash_w,
    input  logic [NBIT-1:0][WW-1:0]  stage_w,
    output logic signed [SW-1:0]     sum_q
);
    typedef struct packed {
        logic signed [SW-1:0] fprod;
        logic signed [SW-1:0] ssum;
        logic signed [SW-1:0] dith;
    } partial_t;

    partial_t             part_c;
    partial_t             part_q;
    logic signed [SW-1:0] acc;

    always_comb begin
        acc = '0;
        for (int k = 0; k < NBIT; k++) begin
            acc = bits[k] ? acc + SW'(stage_w[k]) : acc - SW'(stage_w[k]);
        end
        part_c.fprod = SW'(level) * $signed(SW'({1'b0, flash_w}));
        part_c.ssum  = acc;
        part_c.dith  = SW'(dith);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q <= '0;
            sum_q  <= '0;
        end else begin
            part_q <= part_c;
            sum_q  <= part_q.fprod + part_q.ssum - part_q.dith;
        end
    end

endmodule

// File: rtl/ccmb_round_sat.sv
module ccmb_round_sat
    import ccmb_pkg::*;
#(
    parameter int SW   = 29,
    parameter int FRAC = CCMB_FRAC,
    parameter int OW   = CCMB_OUT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic signed [SW-1:0]  sum_in,
    output logic signed [OW-1:0]  code_q
);
    localparam longint HALF_L = longint'(1) << (FRAC - 1);
    localparam longint MAX_L  = (longint'(1) << (OW - 1)) - 1;
    localparam longint MIN_L  = -(longint'(1) << (OW - 1));

    localparam logic signed [SW-1:0] HALF_S = SW'(HALF_L);
    localparam logic signed [SW-1:0] MAX_S  = SW'(MAX_L);
    localparam logic signed [SW-1:0] MIN_S  = SW'(MIN_L);
    localparam logic signed [SW-1:0] LIM_HI = SW'(MAX_L * (longint'(1) << FRAC) + HALF_L - 1);
    localparam logic signed [SW-1:0] LIM_LO = SW'(MIN_L * (longint'(1) << FRAC) - HALF_L);

    logic signed [SW-1:0] biased;
    logic signed [SW-1:0] shifted;
    sat_e                 sat_kind;

    always_comb begin
        biased  = sum_in + HALF_S;
        shifted = biased >>> FRAC;
        if (shifted > MAX_S) begin
            sat_kind = SAT_HIGH;
        end else if (shifted < MIN_S) begin
            sat_kind = SAT_LOW;
        end else begin
            sat_kind = SAT_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else begin
            case (sat_kind)
                SAT_HIGH: code_q <= OW'(MAX_L);
                SAT_LOW:  code_q <= OW'(MIN_L);
                default:  code_q <= shifted[OW-1:0];
            endcase
        end
    end

    // R8: sums beyond the representable range clamp to the extremes
    assert_sat_hi_R8: assert property (@(posedge clk) disable iff (rst)
        (sum_in > LIM_HI) |=> code_q == OW'(MAX_L));

    assert_sat_lo_R8: assert property (@(posedge clk) disable iff (rst)
        (sum_in < LIM_LO) |=> code_q == OW'(MIN_L));

endmodule

// File: rtl/pipe_code_combiner.sv
module pipe_code_combiner
    import ccmb_pkg::*;
#(
    parameter int     OW           = CCMB_OUT_W,
    parameter int     FRAC         = CCMB_FRAC,
    parameter int     WW           = CCMB_WGT_W,
    parameter int     FLASH_LEVELS = CCMB_FLASH_LEVELS,
    parameter int     NBIT         = CCMB_BIT_STAGES,
    parameter int     NCAL         = CCMB_CAL_STAGES,
    parameter int     DW           = CCMB_DITH_W,
    parameter longint FLASH_NOM    = CCMB_FLASH_NOM,
    parameter longint STAGE_NOM    = CCMB_STAGE_NOM,
    localparam int    AW           = $clog2(NCAL + 2)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [WW-1:0]            wr_data,
    input  logic                     in_valid,
    input  logic [FLASH_LEVELS-2:0]  flash_therm,
    input  logic [NBIT-1:0]          stage_bits,
    input  logic [DW-1:0]            dither,
    output logic                     out_valid,
    output logic [OW-1:0]            out_code
);
    localparam int LW    = $clog2(FLASH_LEVELS) + 1;
    localparam int SW0   = WW + LW + $clog2(NBIT + 1) + 2;
    localparam int SW    = (SW0 > DW + 2) ? SW0 : DW + 2;
    localparam int DEPTH = 4;

    logic [WW-1:0]            flash_w;
    logic [NBIT-1:0][WW-1:0]  stage_w;
    logic signed [LW-1:0]     level_a;
    logic [NBIT-1:0]          bits_a;
    logic signed [DW-1:0]     dith_a;
    logic signed [SW-1:0]     sum_c;
    logic signed [OW-1:0]     code_d;
    logic [DEPTH-1:0]         vld_q;
    logic [2:0]               since_rst;

    ccmb_weight_regs #(
        .WW(WW), .NBIT(NBIT), .NCAL(NCAL), .AW(AW),
        .FLASH_NOM(FLASH_NOM), .STAGE_NOM(STAGE_NOM)
    ) u_wregs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .flash_w(flash_w), .stage_w(stage_w)
    );

    ccmb_flash_decode #(.LEVELS(FLASH_LEVELS), .LW(LW)) u_flash (
        .clk(clk), .rst(rst), .thermo(flash_therm), .level_q(level_a)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_a <= '0;
            dith_a <= '0;
            vld_q  <= '0;
        end else begin
            bits_a <= stage_bits;
            dith_a <= $signed(dither);
            vld_q  <= {vld_q[DEPTH-2:0], in_valid};
        end
    end

    ccmb_term_sum #(.WW(WW), .NBIT(NBIT), .LW(LW), .DW(DW), .SW(SW)) u_sum (
        .clk(clk), .rst(rst), .level(level_a), .bits(bits_a), .dith(dith_a),
        .flash_w(flash_w), .stage_w(stage_w), .sum_q(sum_c)
    );

    ccmb_round_sat #(.SW(SW), .FRAC(FRAC), .OW(OW)) u_rsat (
        .clk(clk), .rst(rst), .sum_in(sum_c), .code_q(code_d)
    );

    assign out_valid = vld_q[DEPTH-1];
    assign out_code  = code_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 3'd4) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    // R1: the valid strobe trails the input strobe by exactly four edges
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R10: the pipeline is empty right after reset
    assert_empty_after_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

// File: tb/pipe_code_combiner_tb.sv
module pipe_code_combiner_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [17:0] wr_data;
    logic        in_valid;
    logic [13:0] flash_therm;
    logic [14:0] stage_bits;
    logic [23:0] dither;
    logic        out_valid;
    logic [13:0] out_code;

    always #5 clk = ~clk;

    pipe_code_combiner u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .in_valid(in_valid), .flash_therm(flash_therm), .stage_bits(stage_bits),
        .dither(dither), .out_valid(out_valid), .out_code(out_code)
    );

    int     checks   = 0;
    int     failures = 0;
    bit     done     = 0;
    int     cyc      = 0;
    longint wmodel [0:15];
    bit     sv [0:3];
    longint sc [0:3];
    string  st [0:3];

    task automatic load_nominal();
        longint w;
        wmodel[0] = 65536;
        w = 38400;
        for (int k = 0; k < 15; k++) begin
            wmodel[k+1] = w;
            w = (w * 10) / 17;
        end
    endtask

    function automatic longint raw_sum(logic [13:0] t, logic [14:0] b);
        longint s;
        s = longint'($countones(t) - 7) * wmodel[0];
        for (int k = 0; k < 15; k++) begin
            s = b[k] ? s + wmodel[k+1] : s - wmodel[k+1];
        end
        return s;
    endfunction

    function automatic longint model(logic [13:0] t, logic [14:0] b, longint d);
        longint s;
        longint r;
        s = raw_sum(t, b) - d;
        r = (s + 32) >>> 6;
        if (r > 8191) r = 8191;
        if (r < -8192) r = -8192;
        return r;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(bit v, logic [13:0] t, logic [14:0] b, longint d, string tag,
                        bit we = 0, logic [3:0] wa = 0, logic [17:0] wd = 0);
        int slot;
        @(negedge clk);
        slot = cyc % 4;
        if (sv[slot]) begin
            check(out_valid === 1'b1 && longint'($signed(out_code)) == sc[slot],
                  st[slot], longint'($signed(out_code)), sc[slot]);
        end else begin
            check(out_valid === 1'b0, "R1 idle slot valid", longint'(out_valid), 0);
        end
        if (we && wa < 4'd11) wmodel[wa] = longint'(wd);
        wr_en       = we;
        wr_addr     = wa;
        wr_data     = wd;
        in_valid    = v;
        flash_therm = t;
        stage_bits  = b;
        dither      = 24'(d);
        sv[slot]    = v;
        sc[slot]    = model(t, b, d);
        st[slot]    = tag;
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0;
        in_valid = 0; flash_therm = 0; stage_bits = 0; dither = 0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && out_code === 14'd0, "R10 reset outputs",
              longint'(out_code), 0);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) sv[i] = 0;
        load_nominal();
    endtask

    function automatic longint rnd_dith(int span);
        return longint'($urandom % (32'd1 << span)) - (longint'(1) << (span - 1));
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [13:0] t;
        longint s0;
        void'($urandom(32'd7));
        rst = 1'b1;
        load_nominal();
        do_reset();

        // R2: ones count sweep, clean thermometer
        for (int n = 0; n <= 14; n++) begin
            step(1, 14'((32'd1 << n) - 1), 15'h5555, 0, "R2 flash count");
        end
        // R2: bubbled thermometers of the same counts
        for (int n = 0; n <= 14; n++) begin
            t = 14'((32'd1 << n) - 1);
            t = 14'((t << ((n * 5) % 14)) | (t >> (14 - (n * 5) % 14)));
            step(1, t, 15'h2AAA, 0, "R2 bubble thermometer");
        end
        // R3 and R5: walking one and walking zero across the stages
        for (int k = 0; k < 15; k++) begin
            step(1, 14'h007F, 15'(32'd1 << k), 0, k < 10 ? "R3 walking one" : "R5 tail walking one");
            step(1, 14'h007F, ~15'(32'd1 << k), 0, k < 10 ? "R3 walking zero" : "R5 tail walking zero");
        end
        // R6: random dither removal
        for (int i = 0; i < 40; i++) begin
            step(1, 14'($urandom), 15'($urandom), rnd_dith(21), "R6 dither removal");
        end
        // R7: exact ties and near ties on both signs
        s0 = raw_sum(14'h0FFF, 15'h1234);
        step(1, 14'h0FFF, 15'h1234, s0 - (64 * 10 + 32), "R7 positive tie");
        step(1, 14'h0FFF, 15'h1234, s0 - (64 * 10 + 31), "R7 below positive tie");
        step(1, 14'h0FFF, 15'h1234, s0 - (-64 * 11 + 32), "R7 negative tie");
        step(1, 14'h0FFF, 15'h1234, s0 - (-64 * 11 + 31), "R7 below negative tie");
        // R8: saturation at both ends
        step(1, 14'h3FFF, 15'h7FFF, 0, "R8 saturate high");
        step(1, 14'h0000, 15'h0000, 0, "R8 saturate low");
        step(1, 14'h007F, 15'h4000, -(longint'(1) << 22), "R8 dither drives high");
        step(1, 14'h007F, 15'h4000, (longint'(1) << 22), "R8 dither drives low");
        // R1: gaps between valid samples
        for (int i = 0; i < 20; i++) begin
            step(i % 3 != 0, 14'($urandom), 15'($urandom), rnd_dith(16), "R1 gapped stream");
        end
        // R4: program every weight register, then stream
        for (int a = 0; a < 11; a++) begin
            step(0, 0, 0, 0, "R4 write", 1, 4'(a), 18'(($urandom % 32'd200000) + 1));
        end
        for (int i = 0; i < 60; i++) begin
            step(1, 14'($urandom), 15'($urandom), rnd_dith(18), "R4 programmed weights");
        end
        // R9: writes to unused addresses
        for (int a = 11; a < 16; a++) begin
            step(0, 0, 0, 0, "R9 write", 1, 4'(a), 18'h3FFFF);
        end
        for (int i = 0; i < 30; i++) begin
            step(1, 14'($urandom), 15'($urandom), rnd_dith(18), "R9 ignored write");
        end
        // R10: reset restores nominal weights
        do_reset();
        for (int i = 0; i < 30; i++) begin
            step(1, 14'($urandom), 15'($urandom), rnd_dith(18), "R10 nominal after reset");
        end
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 0, 0, "R1 flush");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule